// File: doc/BRIEF.md
# Configurable-Parity Serial Frame Transmitter

This block turns one data word into an asynchronous serial frame on a single output line. A frame is a low start bit, then 5 to 8 data bits sent least-significant bit first, then an optional parity bit, then one or two high stop bits. The word enters through a valid/ready handshake. Three configuration inputs choose the data length, the parity mode (none, even, odd) and the stop-bit count. These inputs are sampled when the word is taken and are held inside the block until the frame ends.

Every bit lasts exactly `CLKS_PER_BIT` clock cycles, counted by a bit-period timer. The sequencer is a five-state machine:
- `ST_IDLE`: line high, ready high.
- `ST_START`: line low.
- `ST_DATA`: one data bit per period, taken from a shift register.
- `ST_PARITY`: the captured parity bit.
- `ST_STOP`: line high, for one or two periods.

The transitions are:
- ACCEPT: `ST_IDLE`→`ST_START`.
- START_DONE: `ST_START`→`ST_DATA`.
- NEXT_BIT: `ST_DATA`→`ST_DATA`, while data bits remain.
- DATA_TO_PARITY: `ST_DATA`→`ST_PARITY`, when parity is on.
- DATA_TO_STOP: `ST_DATA`→`ST_STOP`, when parity is off.
- PARITY_DONE: `ST_PARITY`→`ST_STOP`.
- SECOND_STOP: `ST_STOP`→`ST_STOP`, when two stop bits are selected.
- FRAME_DONE: `ST_STOP`→`ST_IDLE`.

Top module: `sertx_frame`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is high, `in_ready` is high and `tx_busy` is low.
- R2: A word is taken on a rising clock edge where `in_valid` and `in_ready` are both high. From the next cycle, `in_ready` is low and `tx_busy` is high for exactly (1 + N + P + S) × `CLKS_PER_BIT` cycles, where N is the data length, P is 1 with parity and 0 without, and S is the stop-bit count. After that there is at least one idle cycle with `in_ready` high.
- R3: The start bit is low and begins in the cycle after the word is taken.
- R4: `cfg_len_code` selects N = 5 + `cfg_len_code` (0→5 bits, 3→8 bits). The data bits follow the start bit, bit 0 first. Bits of `in_data` at positions N and above do not appear on the line.
- R5: `cfg_parity` is decoded as 0 = none, 1 = even, 2 = odd, and 3 is treated as none. With parity on, the parity bit sits directly after the last data bit and before the stop bits. With parity off, no parity bit is sent at all.
- R6: In even mode the parity bit is the XOR of the N sent data bits, so the count of ones including the parity bit is even. In odd mode it is the inverse of that XOR. Word 0x29, sent with 8 bits and even parity, carries a parity bit of 1.
- R7: `cfg_two_stop` = 0 sends one stop bit and 1 sends two, all high. The last stop bit is high right up to the return to idle.
- R8: Each start, data, parity and stop bit holds its level for exactly `CLKS_PER_BIT` cycles.
- R9: The configuration inputs are sampled with the word. Changes to them during a frame do not alter that frame.
- R10: While `tx_busy` is high, `in_valid` and `in_data` have no effect, and no word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block can take a word (idle) |
| in_data | input | DATA_W | Word to send, bit 0 first |
| cfg_len_code | input | 2 | Data length code, N = 5 + code |
| cfg_parity | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | Frame in progress |

## Verification
Two things can land in the same cycle: taking a new word, and a change on the configuration inputs. The bench changes the configuration in the very cycle after a word is taken, and it also offers a new word in the first idle cycle after a stop bit. The reference model builds the whole expected frame only from values seen at the taking edge. Every cycle of the line is compared with that model, so a frame that picks up late configuration, or loses or gains the idle cycle, is flagged at the first wrong sample.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_RSVD = 2'd3
    } par_mode_e;

    typedef struct packed {
        logic [1:0] len_code;
        par_mode_e  par;
        logic       two_stop;
    } frame_cfg_t;

endpackage

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);                                                  // R8
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));                                         // R8

endmodule

// File: rtl/sertx_parity.sv
module sertx_parity
    import sertx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len_code,
    input  par_mode_e         mode,
    output logic              par_bit
);
    logic [DATA_W-1:0] masked;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        if (i < MIN_LEN) begin : g_always
            assign masked[i] = data[i];
        end else begin : g_cond
            assign masked[i] = data[i] && (32'(len_code) + MIN_LEN > i);
        end
    end

    always_comb begin
        unique case (mode)
            PAR_EVEN: par_bit = ^masked;
            PAR_ODD:  par_bit = ~^masked;
            default:  par_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/sertx_shift_reg.sv
module sertx_shift_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              lsb
);
    logic [DATA_W-1:0] sr_q;

    assign lsb = sr_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_data;
        end else if (shift) begin
            sr_q <= {1'b0, sr_q[DATA_W-1:1]};
        end
    end

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
    import sertx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    parameter int DATA_W       = 8,
    parameter int MIN_LEN      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        cfg_len_code,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_two_stop,
    output logic              tx_line,
    output logic              tx_busy
);
    localparam int IDXW = $clog2(DATA_W);

    tx_state_e       state_q, state_d;
    logic [IDXW-1:0] bit_idx_q, bit_idx_d;
    logic            stop_idx_q, stop_idx_d;
    frame_cfg_t      cfg_q, cfg_in;
    logic            par_q, par_calc;
    logic            accept, bit_tick, data_bit, shift_en;
    logic [IDXW-1:0] last_idx;
    logic            par_on;

    assign cfg_in   = '{len_code: cfg_len_code, par: par_mode_e'(cfg_parity), two_stop: cfg_two_stop};
    assign accept   = in_valid && in_ready;
    assign last_idx = IDXW'(MIN_LEN - 1) + IDXW'(cfg_q.len_code);
    assign par_on   = (cfg_q.par == PAR_EVEN) || (cfg_q.par == PAR_ODD);
    assign shift_en = (state_q == ST_DATA) && bit_tick;

    sertx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q != ST_IDLE),
        .tick (bit_tick)
    );

    sertx_parity #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) parity_i (
        .data    (in_data),
        .len_code(cfg_in.len_code),
        .mode    (cfg_in.par),
        .par_bit (par_calc)
    );

    sertx_shift_reg #(.DATA_W(DATA_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_data(in_data),
        .shift    (shift_en),
        .lsb      (data_bit)
    );

    // Next-state logic
    always_comb begin
        state_d    = state_q;
        bit_idx_d  = bit_idx_q;
        stop_idx_d = stop_idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d    = ST_START;          // ACCEPT
                    bit_idx_d  = '0;
                    stop_idx_d = 1'b0;
                end
            end
            ST_START: begin
                if (bit_tick) state_d = ST_DATA;    // START_DONE
            end
            ST_DATA: begin
                if (bit_tick) begin
                    if (bit_idx_q == last_idx) begin
                        state_d = par_on ? ST_PARITY : ST_STOP;  // DATA_TO_PARITY / DATA_TO_STOP
                    end else begin
                        bit_idx_d = bit_idx_q + 1'b1;            // NEXT_BIT
                    end
                end
            end
            ST_PARITY: begin
                if (bit_tick) state_d = ST_STOP;    // PARITY_DONE
            end
            ST_STOP: begin
                if (bit_tick) begin
                    if (cfg_q.two_stop && !stop_idx_q) begin
                        stop_idx_d = 1'b1;          // SECOND_STOP
                    end else begin
                        state_d = ST_IDLE;          // FRAME_DONE
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            bit_idx_q  <= '0;
            stop_idx_q <= 1'b0;
            cfg_q      <= '{len_code: 2'd0, par: PAR_NONE, two_stop: 1'b0};
            par_q      <= 1'b0;
        end else begin
            state_q    <= state_d;
            bit_idx_q  <= bit_idx_d;
            stop_idx_q <= stop_idx_d;
            if (accept) begin
                cfg_q <= cfg_in;
                par_q <= par_calc;
            end
        end
    end

    // Outputs
    always_comb begin
        in_ready = 1'b0;
        tx_busy  = 1'b1;
        tx_line  = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                tx_busy  = 1'b0;
            end
            ST_START:  tx_line = 1'b0;
            ST_DATA:   tx_line = data_bit;
            ST_PARITY: tx_line = par_q;
            ST_STOP:   tx_line = 1'b1;
            default:   tx_line = 1'b1;
        endcase
    end

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !tx_line);                                            // R3
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (tx_busy && !in_ready));                              // R2
    AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !bit_tick) |=> $stable(tx_line));                    // R8
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !accept) |=> $stable(cfg_q) && $stable(par_q));      // R9
    AST_ENDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && bit_tick && (state_d == ST_IDLE)) |-> tx_line);      // R7
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (bit_idx_q <= last_idx));               // R4
    AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && in_valid) |=> $stable(cfg_q));                       // R10

endmodule

// File: tb/sertx_frame_tb.sv
module sertx_frame_tb_top;
    localparam int C = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic [1:0] cfg_len_code = '0;
    logic [1:0] cfg_parity = '0;
    logic       cfg_two_stop = 1'b0;
    logic       in_ready, tx_line, tx_busy;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string phase = "";

    bit    q_val[$];
    string q_tag[$];

    always #5 clk = ~clk;

    sertx_frame #(.CLKS_PER_BIT(C), .DATA_W(8), .MIN_LEN(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .cfg_len_code(cfg_len_code), .cfg_parity(cfg_parity),
        .cfg_two_stop(cfg_two_stop), .tx_line(tx_line), .tx_busy(tx_busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, phase, act, exp, $time);
        end
    endtask

    // Every bit is pushed C times (R8)
    task automatic push_bit(input bit v, input string tag);
        for (int k = 0; k < C; k++) begin
            q_val.push_back(v);
            q_tag.push_back(tag);
        end
    endtask

    task automatic build_frame(input logic [7:0] d, input int code, input int pm, input bit two);
        int n = 5 + code;
        int ones = 0;
        push_bit(1'b0, "R3");
        for (int i = 0; i < n; i++) begin
            push_bit(d[i], "R4 R8");
            if (d[i]) ones++;
        end
        if (pm == 1) push_bit((ones % 2) == 1, "R5 R6");
        else if (pm == 2) push_bit((ones % 2) == 0, "R5 R6");
        push_bit(1'b1, "R7");
        if (two) push_bit(1'b1, "R7");
    endtask

    // Reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            q_val.delete();
            q_tag.delete();
        end else if (q_val.size() != 0) begin
            void'(q_val.pop_front());
            void'(q_tag.pop_front());
        end else if (in_valid) begin
            build_frame(in_data, int'(cfg_len_code), int'(cfg_parity), cfg_two_stop);
        end
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q_val.size() != 0) begin
                check(q_tag[0], int'(tx_line), int'(q_val[0]));
                check("R2 ready", int'(in_ready), 0);
                check("R2 busy", int'(tx_busy), 1);
            end else begin
                check("R1 line", int'(tx_line), 1);
                check("R1 ready", int'(in_ready), 1);
                check("R1 busy", int'(tx_busy), 0);
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic [1:0] l, input logic [1:0] p, input bit s);
        wait_idle();
        in_valid = 1'b1; in_data = d; cfg_len_code = l; cfg_parity = p; cfg_two_stop = s;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset line", int'(tx_line), 1);
        check("R1 reset ready", int'(in_ready), 1);
        check("R1 reset busy", int'(tx_busy), 0);
        rst_n = 1'b1;

        // R6: 0x29 even parity, explicit mid-bit sample of the parity bit
        phase = "R6 0x29";
        send(8'h29, 2'd3, 2'd1, 1'b0);
        repeat (9 * C + C / 2 - 1) @(negedge clk);
        check("R6 parity of 0x29", int'(tx_line), 1);

        // R9: configuration changed in the cycle right after the taking edge
        phase = "R9";
        send(8'hB5, 2'd1, 2'd2, 1'b1);
        cfg_len_code = 2'd3; cfg_parity = 2'd0; cfg_two_stop = 1'b0;
        repeat (3 * C) @(negedge clk);
        cfg_parity = 2'd1; cfg_len_code = 2'd0;

        // R10: valid and data toggled while busy
        phase = "R10";
        send(8'h0F, 2'd2, 2'd0, 1'b0);
        for (int i = 0; i < 8 * C; i++) begin
            in_valid = i[0]; in_data = 8'(i * 37);
            @(negedge clk);
            if (in_ready) break;
        end
        in_valid = 1'b0;

        // R5: reserved parity code behaves as none; R4 upper bits dropped
        phase = "R5 R4";
        send(8'hE0, 2'd0, 2'd3, 1'b0);
        send(8'hFF, 2'd0, 2'd2, 1'b1);

        // Back-to-back: valid held into the first idle cycle (R2)
        phase = "R2 b2b";
        wait_idle();
        in_valid = 1'b1; in_data = 8'h5A; cfg_len_code = 2'd3; cfg_parity = 2'd1; cfg_two_stop = 1'b0;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data = 8'hC3; cfg_parity = 2'd2;
        @(negedge clk);
        in_valid = 1'b0;

        // Random sweep
        phase = "sweep";
        for (int f = 0; f < 80; f++) begin
            send(8'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
            if (($urandom % 3) == 0) repeat ($urandom % 5) @(negedge clk);
        end
        wait_idle();
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule